// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Front End

This block is the digital side of a two-channel 12-bit digital-to-analog converter. A host writes codes over a parallel bus into a staging register for each channel. It then commits both staged codes to the converter-facing output registers with one command, so the two analog outputs change together. The bus is either 12 bits wide or 8 bits wide. On an 8-bit host the data is left-justified: a full-width write loads the top eight bits, and a second, narrow write takes the low nibble from the top four data lines.

Each output register stores the code in segmented form. The top three bits become a seven-bit thermometer field of equally weighted levels. The remaining nine bits pass through unchanged. A clear command or reset drives both outputs to midscale in offset binary (code 0x800). All control inputs are sampled level-sensitively on the rising clock edge.

Top module: `dual_dac_front`

## Requirements
- R1: While reset is low, and after it, until the first transfer or clear, both outputs hold midscale: seg = 7'b0001111 and lsb = 9'h000.
- R2: When wide_sel = 1, a write stores all twelve bus_d bits unchanged in the addressed staging register.
- R3: When wide_sel = 0, a write stores bus_d[11:8] into staging bits [3:0], and staging bits [11:4] keep their value.
- R4: A staging register changes only on an edge where cs, wr1 and its address bit are all 1. Otherwise it holds.
- R5: adr[0] addresses channel A and adr[1] addresses channel B. With both bits set, both channels load the same data.
- R6: On an edge with wr2 = 1 and xfer = 1, both output registers load from their staging registers. Without wr2, xfer has no effect, and the outputs hold between commands.
- R7: On an edge with wr2 = 1 and clr = 1, both outputs go to midscale and the staging registers are untouched. Clear wins over transfer. Without wr2, clr has no effect.
- R8: For a staged code c, seg has its lowest c[11:9] bits set (bit 0 first) and the rest clear, and lsb = c[8:0].
- R9: If a write and a transfer fall on the same edge, the outputs take the staging contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_d | input | 12 | Parallel data bus |
| wide_sel | input | 1 | 1: full 12-bit load; 0: low-nibble load from bus_d[11:8] |
| cs | input | 1 | Chip select, gates every write |
| wr1 | input | 1 | Staging write strobe |
| adr | input | 2 | Channel select, bit 0 = A, bit 1 = B |
| wr2 | input | 1 | Command strobe for transfer and clear |
| xfer | input | 1 | Transfer both staging registers to the outputs |
| clr | input | 1 | Force both outputs to midscale |
| seg_a | output | 7 | Channel A thermometer field |
| lsb_a | output | 9 | Channel A low nine bits |
| seg_b | output | 7 | Channel B thermometer field |
| lsb_b | output | 9 | Channel B low nine bits |

## Verification
A write reaches the staging register on the same rising edge that samples it. A command changes the outputs on the rising edge that samples wr2. So each output result is due exactly one edge after its command is driven. The bench drives inputs on falling edges and compares the outputs at the next falling edge, half a cycle after the edge that loaded them. Writes can only be seen through a later transfer, so every staging check pairs a write with a transfer. The expected code is then compared in both segmented fields. For R9, the write and the transfer share one edge, and the old contents are expected.

// File: rtl/dual_dac_front.sv
module dual_dac_front #(
  parameter int DW  = 12,
  parameter int SEG = 3,
  parameter int NIB = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DW-1:0]         bus_d,
  input  logic                  wide_sel,
  input  logic                  cs,
  input  logic                  wr1,
  input  logic [1:0]            adr,
  input  logic                  wr2,
  input  logic                  xfer,
  input  logic                  clr,
  output logic [(2**SEG)-2:0]   seg_a,
  output logic [DW-SEG-1:0]     lsb_a,
  output logic [(2**SEG)-2:0]   seg_b,
  output logic [DW-SEG-1:0]     lsb_b
);
  localparam int LW  = DW - SEG;
  localparam int THW = (2**SEG) - 1;
  localparam logic [DW-1:0] MID = DW'(1) << (DW-1);

  function automatic logic [THW-1:0] therm(input logic [SEG-1:0] k);
    logic [THW-1:0] t;
    for (int j = 0; j < THW; j++) t[j] = (32'(k) > j);
    return t;
  endfunction

  localparam logic [THW-1:0] MID_SEG = therm(MID[DW-1 -: SEG]);

  logic [DW-1:0]  stg_q [2];
  logic [THW-1:0] seg_q [2];
  logic [LW-1:0]  lsb_q [2];

  wire cmd_clr  = wr2 & clr;
  wire cmd_xfer = wr2 & xfer & ~clr;

  for (genvar i = 0; i < 2; i++) begin : g_ch
    wire wen = cs & wr1 & adr[i];
    wire [DW-1:0] stg_d = wide_sel ? bus_d : {stg_q[i][DW-1:NIB], bus_d[DW-1 -: NIB]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stg_q[i] <= MID;
      else if (wen) stg_q[i] <= stg_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q[i] <= MID_SEG;
        lsb_q[i] <= '0;
      end else if (cmd_clr) begin
        seg_q[i] <= MID_SEG;
        lsb_q[i] <= '0;
      end else if (cmd_xfer) begin
        seg_q[i] <= therm(stg_q[i][DW-1 -: SEG]);
        lsb_q[i] <= stg_q[i][LW-1:0];
      end
    end

    a_r4_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && wr1 && adr[i]) |=> $stable(stg_q[i]));
    a_r2_wide_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr1 && adr[i] && wide_sel) |=> stg_q[i] == $past(bus_d));
    a_r3_nibble_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr1 && adr[i] && !wide_sel) |=>
        (stg_q[i][DW-1:NIB] == $past(stg_q[i][DW-1:NIB])) &&
        (stg_q[i][NIB-1:0] == $past(bus_d[DW-1 -: NIB])));
    a_r7_clear_mid: assert property (@(posedge clk) disable iff (!rst_n)
      (wr2 && clr) |=> (seg_q[i] == MID_SEG) && (lsb_q[i] == '0));
    a_r6_xfer_low: assert property (@(posedge clk) disable iff (!rst_n)
      (wr2 && xfer && !clr) |=> lsb_q[i] == $past(stg_q[i][LW-1:0]));
    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr2 && (clr || xfer)) |=> $stable(seg_q[i]) && $stable(lsb_q[i]));
    a_r8_therm_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_q[i] & (seg_q[i] + 1'b1)) == '0);
  end

  assign seg_a = seg_q[0];
  assign lsb_a = lsb_q[0];
  assign seg_b = seg_q[1];
  assign lsb_b = lsb_q[1];
endmodule

// File: tb/dual_dac_front_bench.sv
module dual_dac_front_bench;
  logic clk = 0, rst_n = 0;
  logic [11:0] bus_d = 0;
  logic wide_sel = 0, cs = 0, wr1 = 0, wr2 = 0, xfer = 0, clr = 0;
  logic [1:0] adr = 0;
  logic [6:0] seg_a, seg_b;
  logic [8:0] lsb_a, lsb_b;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dual_dac_front u_dual_dac_front (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .wide_sel(wide_sel), .cs(cs),
    .wr1(wr1), .adr(adr), .wr2(wr2), .xfer(xfer), .clr(clr),
    .seg_a(seg_a), .lsb_a(lsb_a), .seg_b(seg_b), .lsb_b(lsb_b));

  // {cs, wr1, wide, adr[1:0], data, expected A, expected B} after write then transfer
  localparam logic [40:0] VEC [13] = '{
    {1'b1,1'b1,1'b1,2'b11,12'hABC,12'hABC,12'hABC},  // R2 R5 both
    {1'b1,1'b1,1'b1,2'b01,12'h123,12'h123,12'hABC},  // R5 A only
    {1'b1,1'b1,1'b1,2'b10,12'hFFF,12'h123,12'hFFF},  // R5 B only
    {1'b1,1'b1,1'b0,2'b01,12'h5A7,12'h125,12'hFFF},  // R3
    {1'b1,1'b1,1'b0,2'b10,12'hE00,12'h125,12'hFFE},  // R3
    {1'b1,1'b1,1'b1,2'b00,12'h777,12'h125,12'hFFE},  // R4 no address
    {1'b1,1'b1,1'b0,2'b11,12'h3FF,12'h123,12'hFF3},  // R3 R5
    {1'b1,1'b1,1'b1,2'b01,12'h000,12'h000,12'hFF3},  // R8 k=0
    {1'b1,1'b1,1'b1,2'b10,12'h800,12'h000,12'h800},  // R8 k=4
    {1'b1,1'b1,1'b1,2'b11,12'hE01,12'hE01,12'hE01},  // R8 k=7
    {1'b0,1'b1,1'b1,2'b11,12'h555,12'hE01,12'hE01},  // R4 no cs
    {1'b1,1'b0,1'b1,2'b11,12'h555,12'hE01,12'hE01},  // R4 no wr1
    {1'b1,1'b1,1'b1,2'b01,12'h555,12'h555,12'hE01}   // R2
  };

  function automatic logic [6:0] seg_of(input logic [11:0] c);
    logic [6:0] t = '0;
    for (int j = 0; j < int'(c[11:9]); j++) t[j] = 1'b1;
    return t;
  endfunction

  task automatic check(input string tag, input logic [11:0] ea, input logic [11:0] eb);
    checks++;
    if (seg_a !== seg_of(ea) || lsb_a !== ea[8:0] || seg_b !== seg_of(eb) || lsb_b !== eb[8:0]) begin
      fails++;
      $display("FAIL %s: A=%b/%h B=%b/%h expected A=%b/%h B=%b/%h", tag,
               seg_a, lsb_a, seg_b, lsb_b, seg_of(ea), ea[8:0], seg_of(eb), eb[8:0]);
    end
  endtask

  task automatic wr(input logic c, input logic w, input logic wd, input logic [1:0] a, input logic [11:0] d);
    @(negedge clk); cs = c; wr1 = w; wide_sel = wd; adr = a; bus_d = d;
    @(negedge clk); cs = 0; wr1 = 0; adr = 0;
  endtask

  task automatic cmd(input logic s2, input logic x, input logic c);
    @(negedge clk); wr2 = s2; xfer = x; clr = c;
    @(negedge clk); wr2 = 0; xfer = 0; clr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset held", 12'h800, 12'h800);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 12'h800, 12'h800);

    for (int i = 0; i < 13; i++) begin
      wr(VEC[i][40], VEC[i][39], VEC[i][38], VEC[i][37:36], VEC[i][35:24]);
      cmd(1, 1, 0);
      check($sformatf("R2-vector %0d", i), VEC[i][23:12], VEC[i][11:0]);
    end

    wr(1, 1, 1, 2'b11, 12'h9AB);
    cmd(0, 1, 0);
    check("R6 xfer without wr2", 12'h555, 12'hE01);
    repeat (5) @(negedge clk);
    check("R6 outputs hold", 12'h555, 12'hE01);
    cmd(0, 0, 1);
    check("R7 clr without wr2", 12'h555, 12'hE01);
    cmd(1, 0, 1);
    check("R7 clear to midscale", 12'h800, 12'h800);
    cmd(1, 1, 0);
    check("R7 staging kept after clear", 12'h9AB, 12'h9AB);
    cmd(1, 1, 1);
    check("R7 clear beats transfer", 12'h800, 12'h800);

    @(negedge clk);
    cs = 1; wr1 = 1; wide_sel = 1; adr = 2'b01; bus_d = 12'h246; wr2 = 1; xfer = 1;
    @(negedge clk);
    cs = 0; wr1 = 0; adr = 0; wr2 = 0; xfer = 0;
    check("R9 same-edge write and transfer", 12'h9AB, 12'h9AB);
    cmd(1, 1, 0);
    check("R9 new value on next transfer", 12'h246, 12'h9AB);

    rst_n = 0;
    @(negedge clk);
    check("R1 mid-run reset", 12'h800, 12'h800);
    rst_n = 1;
    cmd(1, 1, 0);
    check("R1 staging reset to midscale", 12'h800, 12'h800);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule